// File: doc/BRIEF.md
# Serial-In Converter Code Receiver

This block is the digital front end of a serial-input digital-to-analog converter. A host drives three wires: an active-low select, a serial clock and a serial data line. While select is low, each rising serial-clock edge pushes one data bit into a shift register, most significant bit first. The shift register keeps only the newest `RES_BITS` bits, so a host may send more bits than the resolution (for example two whole bytes into a 14-bit receiver) and the surplus leading bits simply fall off the top.

No bit counter is used. The code is moved from the shift register into the held converter register when select goes high again; at all other times the held code stays put. The receiver runs on a fast system clock, brings the three wires in through two-flop synchronizers and finds edges by comparing the current and previous synchronized samples, so the system clock must run at least four times the serial clock. A one-cycle update strobe marks each transfer, and a one-cycle error strobe marks a serial-clock edge seen in the same sampled cycle as the select rise.

Top module: `dac_serial_rx`

## Requirements
- R1: After reset the held code is 0, the update strobe is 0 and the error strobe is 0; the internal shift register also starts at 0.
- R2: With select low, each rising serial-clock edge shifts the data bit in at bit 0, moving earlier bits toward bit `RES_BITS-1`; the first bit sent therefore lands highest.
- R3: When more than `RES_BITS` bits are sent in one frame, only the last `RES_BITS` bits reach the held code.
- R4: The held code changes only on a select rise; during a frame it keeps the previous value.
- R5: While select is high, serial-clock edges change neither register.
- R6: With `RES_BITS`=14 and a 16-bit frame, the held code equals the last 14 bits sent.
- R7: A serial-clock edge (either direction) sampled in the same cycle as the select rise pulses the error strobe for one cycle; a clean transfer leaves it at 0.
- R8: The update strobe is high for exactly one system clock per select rise, in the same cycle the new held code first appears.
- R9: A frame shorter than `RES_BITS` keeps the older bits: the held code becomes the previous shift-register contents shifted left by the frame length with the new bits in the low positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n_pin | input | 1 | Serial select, active low, asynchronous |
| sclk_pin | input | 1 | Serial clock, asynchronous |
| sdata_pin | input | 1 | Serial data, asynchronous |
| dac_code | output | RES_BITS | Held converter code |
| update_pulse | output | 1 | One-cycle strobe on each transfer |
| proto_err | output | 1 | One-cycle strobe on a clock edge during the select rise |

## Verification
Every wire change reaches the logic after two synchronizer flops, and the resulting shift or transfer is registered on the third system-clock edge after the wire moved, so the held code and both strobes are due in the cycle after the third rising edge. The bench drives wires on falling edges, counts exactly three rising edges after a select rise and samples on the following falling edge, then checks one cycle later that the strobe has dropped. Mid-frame checks are taken after all bits have been shifted but before select rises, to confirm the held code has not moved. Two instances of 16 and 14 bits receive the same stimulus, and the expected codes come from a bench-side record of all bits sent.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  function automatic logic rise_of(input logic prev_v, input logic cur_v);
    return cur_v & ~prev_v;
  endfunction

  function automatic logic fall_of(input logic prev_v, input logic cur_v);
    return prev_v & ~cur_v;
  endfunction
endpackage

// File: rtl/dsr_sync.sv
module dsr_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= RST_VAL;
    else        st[0] <= d_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[i] <= RST_VAL;
      else        st[i] <= st[i-1];
    end
  end

  assign q_out = st[STAGES-1];
endmodule

// File: rtl/dsr_edge.sv
module dsr_edge #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  import dsr_pkg::*;
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= cur;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign rise[i] = rise_of(prev_q[i], cur[i]);
    assign fall[i] = fall_of(prev_q[i], cur[i]);
  end
endmodule

// File: rtl/dsr_shift.sv
module dsr_shift #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [N-1:0] sr_q
);
  function automatic logic [N-1:0] push_bit(input logic [N-1:0] cur, input logic b);
    return {cur[N-2:0], b};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr_q <= '0;
    else if (shift_en) sr_q <= push_bit(sr_q, bit_in);
  end
endmodule

// File: rtl/dsr_hold.sv
module dsr_hold #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         clash,
  input  logic [N-1:0] sr_in,
  output logic [N-1:0] code_q,
  output logic         pulse_q,
  output logic         err_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      pulse_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      pulse_q <= load;
      err_q   <= load & clash;
      if (load) code_q <= sr_in;
    end
  end
endmodule

// File: rtl/dac_serial_rx.sv
module dac_serial_rx #(
  parameter int RES_BITS = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_n_pin,
  input  logic                sclk_pin,
  input  logic                sdata_pin,
  output logic [RES_BITS-1:0] dac_code,
  output logic                update_pulse,
  output logic                proto_err
);
  localparam int PINS = 3;
  localparam int P_SEL = 2;
  localparam int P_CLK = 1;
  localparam int P_DAT = 0;
  localparam logic [PINS-1:0] PIN_IDLE = 3'b100;

  logic [PINS-1:0] pins_s;
  logic [1:0]      edge_r;
  logic [1:0]      edge_f;
  logic            cs_hi_w;
  logic            cs_rise_w;
  logic            sclk_rise_w;
  logic            sclk_edge_w;
  logic            shift_en_w;
  logic [RES_BITS-1:0] shift_q;

  dsr_sync #(.W(PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_in({sel_n_pin, sclk_pin, sdata_pin}),
    .q_out(pins_s)
  );

  dsr_edge #(.W(2), .RST_VAL(PIN_IDLE[P_SEL:P_CLK])) u_edge (
    .clk(clk), .rst_n(rst_n),
    .cur(pins_s[P_SEL:P_CLK]),
    .rise(edge_r), .fall(edge_f)
  );

  assign cs_hi_w     = pins_s[P_SEL];
  assign cs_rise_w   = edge_r[1];
  assign sclk_rise_w = edge_r[0];
  assign sclk_edge_w = edge_r[0] | edge_f[0];
  assign shift_en_w  = ~cs_hi_w & sclk_rise_w;

  dsr_shift #(.N(RES_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .shift_en(shift_en_w), .bit_in(pins_s[P_DAT]),
    .sr_q(shift_q)
  );

  dsr_hold #(.N(RES_BITS)) u_hold (
    .clk(clk), .rst_n(rst_n),
    .load(cs_rise_w), .clash(sclk_edge_w),
    .sr_in(shift_q),
    .code_q(dac_code), .pulse_q(update_pulse), .err_q(proto_err)
  );
endmodule

// File: rtl/dac_serial_rx_chk.sv
module dac_serial_rx_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_high,
  input logic         cs_rise,
  input logic [W-1:0] shift_q,
  input logic [W-1:0] dac_code,
  input logic         update_pulse,
  input logic         proto_err
);
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    update_pulse |=> !update_pulse);

  a_r4_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    !update_pulse |-> $stable(dac_code));

  a_r2_transfer_value: assert property (@(posedge clk) disable iff (!rst_n)
    update_pulse |-> dac_code == $past(shift_q));

  a_r5_idle_no_shift: assert property (@(posedge clk) disable iff (!rst_n)
    cs_high |=> $stable(shift_q));

  a_r7_err_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> update_pulse);

  a_r8_pulse_from_rise: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> update_pulse);
endmodule

bind dac_serial_rx dac_serial_rx_chk #(.W(RES_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cs_high(cs_hi_w), .cs_rise(cs_rise_w),
  .shift_q(shift_q), .dac_code(dac_code),
  .update_pulse(update_pulse), .proto_err(proto_err)
);

// File: tb/dac_serial_rx_bench.sv
module dac_serial_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1, sclk = 1'b0, sdata = 1'b0;
  logic [15:0] code16;
  logic [13:0] code14;
  logic upd16, upd14, err16, err14;
  int errors = 0, checks = 0;
  logic [15:0] sent;      // record of last 16 bits shifted
  logic [15:0] held;      // expected held code (16-bit view)

  always #4 clk = ~clk;

  dac_serial_rx #(.RES_BITS(16)) u_dac_serial_rx (
    .clk(clk), .rst_n(rst_n), .sel_n_pin(sel_n), .sclk_pin(sclk),
    .sdata_pin(sdata), .dac_code(code16), .update_pulse(upd16), .proto_err(err16));

  dac_serial_rx #(.RES_BITS(14)) u_dac_serial_rx14 (
    .clk(clk), .rst_n(rst_n), .sel_n_pin(sel_n), .sclk_pin(sclk),
    .sdata_pin(sdata), .dac_code(code14), .update_pulse(upd14), .proto_err(err14));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_transfer(input string req, input logic exp_err);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({req, " R8 strobe16"}, upd16, 1);
    chk({req, " R8 strobe14"}, upd14, 1);
    chk({req, " code16"}, code16, sent);
    chk({req, " R6 code14"}, code14, sent[13:0]);
    chk({req, " R7 err16"}, err16, exp_err);
    chk({req, " R7 err14"}, err14, exp_err);
    held = sent;
    @(negedge clk);
    chk({req, " R8 strobe drop"}, upd16, 0);
    chk({req, " R7 err drop"}, err16, 0);
  endtask

  task automatic frame(input string req, input logic [31:0] word, input int nbits);
    sel_n = 1'b0;
    wait_n(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdata = word[i];
      wait_n(4);
      sclk = 1'b1;
      wait_n(4);
      sclk = 1'b0;
      sent = {sent[14:0], word[i]};
    end
    wait_n(4);
    chk({req, " R4 mid-frame16"}, code16, held);
    chk({req, " R4 mid-frame14"}, code14, held[13:0]);
    sel_n = 1'b1;
    check_transfer(req, 1'b0);
    wait_n(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    sent = '0;
    held = '0;
    wait_n(3);
    chk("R1 code16", code16, 0);
    chk("R1 code14", code14, 0);
    chk("R1 strobe", upd16, 0);
    chk("R1 err", err16, 0);
    rst_n = 1'b1;
    wait_n(6);
    chk("R1 idle after reset", upd16 | err16, 0);

    // R1: empty frame exposes zero shift register
    frame("R1 empty", 32'h0, 0);
    // R2: plain 16-bit word, MSB first
    frame("R2 word", 32'hA5C3, 16);
    // R3: 20 bits, leading four dropped
    frame("R3 long", 32'hF1234, 20);
    // R6: 16-bit frame into 14-bit instance
    frame("R6 two bytes", 32'hBEEF, 16);
    // R9: short frame keeps older bits
    frame("R9 short", 32'h5, 3);

    // R5: clock toggles while select high have no effect
    for (int i = 0; i < 6; i++) begin
      sdata = i[0];
      wait_n(4);
      sclk = 1'b1;
      wait_n(4);
      sclk = 1'b0;
    end
    wait_n(4);
    chk("R5 code unchanged", code16, held);
    frame("R5 empty after idle clocks", 32'h0, 0);

    // R7: clock edge in same cycle as select rise
    sel_n = 1'b0;
    wait_n(4);
    sel_n = 1'b1;
    sclk = 1'b1;
    check_transfer("R7 clash", 1'b1);
    sclk = 1'b0;
    wait_n(8);

    // sweep of lengths and patterns
    for (int k = 0; k < 28; k++) begin
      int nb;
      logic [31:0] w;
      case (k % 7)
        0: nb = 16; 1: nb = 18; 2: nb = 14; 3: nb = 24;
        4: nb = 1;  5: nb = 8;  default: nb = 17;
      endcase
      w = (k * 32'h9E3779B1) ^ (k << 7);
      frame("R3/R9 sweep", w, nb);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule